// File: doc/BRIEF.md
# Eight-Channel Event Counter Bank

This block keeps one 16-bit event counter for each of eight digital inputs. Every input passes through a two-stage synchroniser and an edge detector. A per-channel polarity bit decides whether rising or falling transitions are counted. Each channel also holds a programmable reload value and a programmable compare value. Three channel masks control counting, overflow flagging and compare flagging.

A host-side command processor drives the block with single-cycle command strobes. Each strobe carries an 8-bit opcode and a 16-bit parameter. Reads answer on a registered response port one cycle later. The overflow and compare flags are sticky. They are merged into a three-bit interrupt-flag word, which the block outputs continuously and also returns on request. Reading the per-channel status clears the flags.

Top module: `evcnt_bank`

## Requirements
- R1: After reset every counter reads 0x0000, every reload value is 0x0000, every compare value is 0x8000, all three masks and the polarity mask are 0, all flags are clear, `irq_flags` is 0 and `rsp_valid` is 0.
- R2: Opcode 0x2C writes the polarity mask, where bit x = 0 counts rising and bit x = 1 counts falling edges of `ev_in[x]`. Opcode 0x28 writes the count-enable mask. A channel whose enable bit is 0 ignores edges. An input edge is counted at the third rising clock edge after it appears.
- R3: Opcode 0x2F returns the counter selected by `cmd_param[2:0]`. Every read opcode (0x2F, 0x60, 0x62) raises `rsp_valid` for exactly the cycle after the command. Any other opcode leaves `rsp_valid` low.
- R4: Opcode 0x40+x writes the reload value of channel x. Opcode 0x29 loads each channel whose bit is set in `cmd_param[7:0]` with its reload value and leaves the other channels unchanged. A reload takes priority over a count edge in the same cycle.
- R5: A counted edge at 0xFFFF loads the channel's reload value. If bit x of the overflow mask (opcode 0x2A) is set, it also sets that channel's overflow flag.
- R6: Opcode 0x48+x writes the compare value of channel x. A counted step whose result equals the compare value sets the channel's compare flag when bit x of the compare mask (opcode 0x2B) is set. Reloads never set it.
- R7: Opcode 0x62 returns overflow flags in bits 15:8 and compare flags in bits 7:0, then clears all flags. A flag set in the same cycle as that read stays set.
- R8: The interrupt-flag word (`irq_flags`, and bits 2:0 of the response to opcode 0x60) has bit 0 = any compare flag, bit 1 = change-of-state (always 0 in this block) and bit 2 = any overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command opcode |
| cmd_param | input | 16 | Command parameter |
| ev_in | input | 8 | Asynchronous event inputs |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_data | output | 16 | Response data |
| irq_flags | output | 3 | Interrupt-flag word |

## Verification
Two collisions can occur in one clock. A status read can clear the flags in the same cycle that a counted step sets a new compare flag. A reload command can land in the same cycle as a count edge on the same channel. The bench raises an input edge and issues the command exactly two clocks later, so both events hit the same edge. It then judges the collision from the ports. The status response must show the old, empty flags, and a second read must still show the new compare flag. After the reload collision, the counter must read the reload value rather than the reload value plus one.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int NCH_DEF = 8;
    localparam int CW_DEF  = 16;

    localparam logic [7:0] OP_CNT_EN    = 8'h28;
    localparam logic [7:0] OP_RELOAD    = 8'h29;
    localparam logic [7:0] OP_OVF_EN    = 8'h2A;
    localparam logic [7:0] OP_MAT_EN    = 8'h2B;
    localparam logic [7:0] OP_EDGE      = 8'h2C;
    localparam logic [7:0] OP_RD_CNT    = 8'h2F;
    localparam logic [7:0] OP_RD_IRQ    = 8'h60;
    localparam logic [7:0] OP_RD_STAT   = 8'h62;
    localparam logic [7:0] OP_RSTV_BASE = 8'h40;
    localparam logic [7:0] OP_MATV_BASE = 8'h48;

    // interrupt-flag word bit positions
    localparam int IRQ_MATCH = 0;
    localparam int IRQ_COS   = 1;
    localparam int IRQ_OVF   = 2;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_CNT  = 2'd1,
        RD_IRQ  = 2'd2,
        RD_STAT = 2'd3
    } rd_kind_e;

    typedef struct packed {
        logic cnt_en;
        logic ovf_en;
        logic mat_en;
    } chan_ctl_t;

    function automatic logic [7:0] op_at(input logic [7:0] base, input int idx);
        return 8'(int'(base) + idx);
    endfunction

endpackage

// File: rtl/evcnt_edge.sv
module evcnt_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    input  logic [N-1:0] fall_sel,
    output logic [N-1:0] ev
);
    logic [N-1:0] s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            s2   <= '0;
            prev <= '0;
        end else begin
            s1   <= din;
            s2   <= s1;
            prev <= s2;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_det
        assign ev[i] = fall_sel[i] ? (prev[i] & ~s2[i]) : (s2[i] & ~prev[i]);
    end
endmodule

// File: rtl/evcnt_cmd_dec.sv
module evcnt_cmd_dec
    import evcnt_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [7:0]     cmd_code,
    input  logic [15:0]    cmd_param,
    output logic [NCH-1:0] en_mask,
    output logic [NCH-1:0] ovf_mask,
    output logic [NCH-1:0] mat_mask,
    output logic [NCH-1:0] fall_mask,
    output logic [NCH-1:0] reload_mask,
    output logic [NCH-1:0] wr_rstv,
    output logic [NCH-1:0] wr_matv,
    output rd_kind_e       rd_kind
);
    logic [NCH-1:0] pmask;
    assign pmask = cmd_param[NCH-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask   <= '0;
            ovf_mask  <= '0;
            mat_mask  <= '0;
            fall_mask <= '0;
        end else if (cmd_valid) begin
            case (cmd_code)
                OP_CNT_EN: en_mask   <= pmask;
                OP_OVF_EN: ovf_mask  <= pmask;
                OP_MAT_EN: mat_mask  <= pmask;
                OP_EDGE:   fall_mask <= pmask;
                default: ;
            endcase
        end
    end

    assign reload_mask = (cmd_valid && cmd_code == OP_RELOAD) ? pmask : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_wr
        assign wr_rstv[i] = cmd_valid && (cmd_code == op_at(OP_RSTV_BASE, i));
        assign wr_matv[i] = cmd_valid && (cmd_code == op_at(OP_MATV_BASE, i));
    end

    always_comb begin
        rd_kind = RD_NONE;
        if (cmd_valid) begin
            case (cmd_code)
                OP_RD_CNT:  rd_kind = RD_CNT;
                OP_RD_IRQ:  rd_kind = RD_IRQ;
                OP_RD_STAT: rd_kind = RD_STAT;
                default:    rd_kind = RD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/evcnt_chan.sv
module evcnt_chan
    import evcnt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_ev,
    input  chan_ctl_t     ctl,
    input  logic          reload,
    input  logic          wr_rstv,
    input  logic          wr_matv,
    input  logic [CW-1:0] wdata,
    input  logic          clr_flags,
    output logic [CW-1:0] cnt,
    output logic          ovf_flag,
    output logic          mat_flag
);
    localparam logic [CW-1:0] MAT_INIT = {1'b1, {(CW-1){1'b0}}};

    logic [CW-1:0] rst_val, mat_val, nxt;
    logic step, at_top, ovf_set, mat_set;

    assign step    = step_ev & ctl.cnt_en & ~reload;
    assign at_top  = (cnt == '1);
    assign nxt     = at_top ? rst_val : cnt + 1'b1;
    assign ovf_set = step & at_top & ctl.ovf_en;
    assign mat_set = step & (nxt == mat_val) & ctl.mat_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            rst_val  <= '0;
            mat_val  <= MAT_INIT;
            ovf_flag <= 1'b0;
            mat_flag <= 1'b0;
        end else begin
            if (wr_rstv) rst_val <= wdata;
            if (wr_matv) mat_val <= wdata;
            if (reload)    cnt <= rst_val;
            else if (step) cnt <= nxt;
            ovf_flag <= (ovf_flag & ~clr_flags) | ovf_set;
            mat_flag <= (mat_flag & ~clr_flags) | mat_set;
        end
    end
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int CW  = CW_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [7:0]     cmd_code,
    input  logic [15:0]    cmd_param,
    input  logic [NCH-1:0] ev_in,
    output logic           rsp_valid,
    output logic [CW-1:0]  rsp_data,
    output logic [2:0]     irq_flags
);
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] en_mask, ovf_mask, mat_mask, fall_mask;
    logic [NCH-1:0] reload_mask, wr_rstv, wr_matv;
    logic [NCH-1:0] ev_vec, ovf_flags, mat_flags;
    logic [CW-1:0]  cnt_arr [NCH];
    logic [NCH*CW-1:0] cnt_flat;
    rd_kind_e       rd_kind;
    logic           clr_flags;
    logic [SELW-1:0] sel;

    evcnt_cmd_dec #(.NCH(NCH)) dec_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_param(cmd_param), .en_mask(en_mask), .ovf_mask(ovf_mask),
        .mat_mask(mat_mask), .fall_mask(fall_mask), .reload_mask(reload_mask),
        .wr_rstv(wr_rstv), .wr_matv(wr_matv), .rd_kind(rd_kind)
    );

    evcnt_edge #(.N(NCH)) edge_i (
        .clk(clk), .rst(rst), .din(ev_in), .fall_sel(fall_mask), .ev(ev_vec)
    );

    assign clr_flags = (rd_kind == RD_STAT);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_ctl_t ctl;
        assign ctl = '{cnt_en: en_mask[i], ovf_en: ovf_mask[i], mat_en: mat_mask[i]};
        evcnt_chan #(.CW(CW)) ch_i (
            .clk(clk), .rst(rst), .step_ev(ev_vec[i]), .ctl(ctl),
            .reload(reload_mask[i]), .wr_rstv(wr_rstv[i]), .wr_matv(wr_matv[i]),
            .wdata(cmd_param[CW-1:0]), .clr_flags(clr_flags),
            .cnt(cnt_arr[i]), .ovf_flag(ovf_flags[i]), .mat_flag(mat_flags[i])
        );
        assign cnt_flat[i*CW +: CW] = cnt_arr[i];
    end

    always_comb begin
        irq_flags            = '0;
        irq_flags[IRQ_MATCH] = |mat_flags;
        irq_flags[IRQ_COS]   = 1'b0;
        irq_flags[IRQ_OVF]   = |ovf_flags;
    end

    assign sel = cmd_param[SELW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (rd_kind != RD_NONE);
            case (rd_kind)
                RD_CNT:  rsp_data <= cnt_arr[sel];
                RD_IRQ:  rsp_data <= CW'(irq_flags);
                RD_STAT: rsp_data <= CW'({ovf_flags, mat_flags});
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/evcnt_bank_chk.sv
module evcnt_bank_chk
    import evcnt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [7:0]        cmd_code,
    input logic              rsp_valid,
    input logic [NCH-1:0]    ev_vec,
    input logic [NCH-1:0]    en_mask,
    input logic [NCH*CW-1:0] cnt_flat,
    input logic [NCH-1:0]    ovf_flags,
    input logic [NCH-1:0]    mat_flags,
    input logic [2:0]        irq_flags
);
    // R3
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(cmd_valid) && ($past(cmd_code) == OP_RD_CNT ||
                       $past(cmd_code) == OP_RD_IRQ || $past(cmd_code) == OP_RD_STAT)));

    // R2
    idle_counts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && (ev_vec & en_mask) == '0) |=> $stable(cnt_flat));

    // R7
    stat_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == OP_RD_STAT && ev_vec == '0) |=>
            (ovf_flags == '0 && mat_flags == '0));

    // R5
    ovf_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flags[IRQ_OVF]) |-> $past((ev_vec & en_mask) != '0));

    // R6
    mat_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flags[IRQ_MATCH]) |-> $past((ev_vec & en_mask) != '0));
endmodule

bind evcnt_bank evcnt_bank_chk #(.NCH(NCH), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rsp_valid(rsp_valid), .ev_vec(ev_vec), .en_mask(en_mask),
    .cnt_flat(cnt_flat), .ovf_flags(ovf_flags), .mat_flags(mat_flags),
    .irq_flags(irq_flags)
);

// File: tb/evcnt_bank_tb.sv
module evcnt_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [15:0] cmd_param = '0;
    logic [7:0]  ev_in = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [2:0]  irq_flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int unsigned m_cnt [8];
    int unsigned m_rv  [8];
    logic [7:0] m_en = '0;
    logic [7:0] m_fall = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evcnt_bank dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_param(cmd_param), .ev_in(ev_in), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .irq_flags(irq_flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] c, input logic [15:0] p);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_param = p;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] c, input logic [15:0] p, input string req,
                      input int exp);
        cmd(c, p);
        chk(rsp_valid == 1'b1, {req, " rsp_valid"}, int'(rsp_valid), 1);
        chk(rsp_data == 16'(exp), req, int'(rsp_data), exp);
    endtask

    task automatic model_edges(input logic [7:0] o, input logic [7:0] n);
        for (int i = 0; i < 8; i++) begin
            if (m_en[i] && ((!m_fall[i] && !o[i] && n[i]) || (m_fall[i] && o[i] && !n[i])))
                m_cnt[i] = (m_cnt[i] == 32'hFFFF) ? m_rv[i] : m_cnt[i] + 1;
        end
    endtask

    task automatic set_ev(input logic [7:0] v);
        model_edges(ev_in, v);
        @(negedge clk);
        ev_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) rd(8'h2F, 16'(i), req, int'(m_cnt[i]));
    endtask

    task automatic set_en(input logic [7:0] e);  m_en = e;   cmd(8'h28, {8'h0, e}); endtask
    task automatic set_fall(input logic [7:0] f); m_fall = f; cmd(8'h2C, {8'h0, f}); endtask

    initial begin
        logic [7:0] en_pat [3];
        logic [7:0] fall_pat [3];
        en_pat   = '{8'hB7, 8'hFF, 8'h6E};
        fall_pat = '{8'h3C, 8'hA5, 8'h0F};
        for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_rv[i] = 0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(irq_flags == 3'b000, "R1 irq_flags", int'(irq_flags), 0);
        check_all("R1 counter");
        rd(8'h62, 0, "R1 status", 0);
        // R1: reset state of the masks: edges with defaults count nothing
        set_ev(8'hFF); set_ev(8'h00);
        check_all("R1 disabled by default");

        // R2 / R3 sweep over enable and polarity patterns
        for (int k = 0; k < 3; k++) begin
            set_en(en_pat[k]);
            set_fall(fall_pat[k]);
            chk(rsp_valid == 1'b0, "R3 no rsp on write", int'(rsp_valid), 0);
            for (int r = 0; r < 2; r++) begin
                set_ev(8'hFF); check_all("R2 rise");
                set_ev(8'h00); check_all("R2 fall");
            end
        end

        // R4 reload with partial and full masks
        for (int i = 0; i < 8; i++) begin
            m_rv[i] = 32'h0100 * i + i + 7;
            cmd(8'h40 + 8'(i), 16'(m_rv[i]));
        end
        cmd(8'h29, 16'h000F);
        for (int i = 0; i < 4; i++) m_cnt[i] = m_rv[i];
        check_all("R4 reload 0x0F");
        cmd(8'h29, 16'h00FF);
        for (int i = 0; i < 8; i++) m_cnt[i] = m_rv[i];
        check_all("R4 reload 0xFF");

        // R5 wrap with and without overflow enable
        set_en(8'h00);
        set_fall(8'h00);
        m_rv[2] = 32'hFFFE; m_rv[5] = 32'hFFFE;
        cmd(8'h42, 16'hFFFE); cmd(8'h45, 16'hFFFE);
        cmd(8'h29, 16'h0024);
        m_cnt[2] = 32'hFFFE; m_cnt[5] = 32'hFFFE;
        cmd(8'h2A, 16'h0004);
        set_en(8'h24);
        set_ev(8'h24); set_ev(8'h00); set_ev(8'h24);
        rd(8'h2F, 2, "R5 wrap ch2", int'(m_cnt[2]));
        rd(8'h2F, 5, "R5 wrap ch5", int'(m_cnt[5]));
        chk(irq_flags == 3'b100, "R8 irq ovf", int'(irq_flags), 4);
        rd(8'h60, 0, "R8 irq read", 4);
        rd(8'h62, 0, "R7 status ovf", 16'h0400);
        rd(8'h62, 0, "R7 status cleared", 0);
        chk(irq_flags == 3'b000, "R7 irq cleared", int'(irq_flags), 0);

        // R6 compare flags
        set_en(8'h00);
        set_ev(8'h00);
        m_rv[1] = 32'h10; m_rv[6] = 32'h10;
        cmd(8'h41, 16'h0010); cmd(8'h46, 16'h0010);
        cmd(8'h29, 16'h0042);
        m_cnt[1] = 32'h10; m_cnt[6] = 32'h10;
        cmd(8'h49, 16'h0011);
        cmd(8'h4E, 16'h0012);
        cmd(8'h2B, 16'h0040);
        set_en(8'h42);
        set_ev(8'h42); set_ev(8'h00);
        chk(irq_flags == 3'b000, "R6 masked compare", int'(irq_flags), 0);
        set_ev(8'h42); set_ev(8'h00);
        chk(irq_flags == 3'b001, "R8 irq match", int'(irq_flags), 1);
        rd(8'h60, 0, "R8 irq read match", 1);
        rd(8'h62, 0, "R6 status match", 16'h0040);
        rd(8'h2F, 6, "R6 count ch6", int'(m_cnt[6]));

        // R7 collision: clear and set in the same cycle
        cmd(8'h4E, 16'h0013);
        set_en(8'h40);
        @(negedge clk); ev_in = 8'h40;
        @(negedge clk);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h62; cmd_param = 0;
        @(negedge clk); cmd_valid = 1'b0;
        m_cnt[6] = m_cnt[6] + 1;
        chk(rsp_valid && rsp_data == 16'h0000, "R7 collision old flags", int'(rsp_data), 0);
        rd(8'h62, 0, "R7 set wins over clear", 16'h0040);
        rd(8'h2F, 6, "R7 count ch6", int'(m_cnt[6]));

        // R4 collision: reload beats a same-cycle edge
        set_ev(8'h00);
        m_rv[6] = 32'h0500;
        cmd(8'h46, 16'h0500);
        @(negedge clk); ev_in = 8'h40;
        @(negedge clk);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h29; cmd_param = 16'h0040;
        @(negedge clk); cmd_valid = 1'b0;
        m_cnt[6] = m_rv[6];
        repeat (4) @(negedge clk);
        rd(8'h2F, 6, "R4 reload beats edge", int'(m_cnt[6]));

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule